// File: doc/BRIEF.md
# Output Driver Impedance Update Sequencer

This block owns the impedance code that sets the strength of a memory's data output drivers. An external comparator reports the code it wants; the sequencer walks the driven code toward that wanted value one step at a time. It moves only on clock edges where the data bus is guaranteed to be high-Z, so a driver never changes strength while it is putting read data on the bus.

The bus is high-Z on write cycles, on deselected cycles, and on any cycle in which the output enable is sampled inactive. Each such edge is an update opportunity. When the impedance reference is open or tied high, the comparator result is ignored and the sequencer heads for the maximum-impedance code. A settle flag reports that the code has agreed with its target on a programmable number of consecutive opportunities.

Top module: `imp_code_sequencer`

## Requirements
- R1: While reset is low, and on the first edge after it is released with no opportunity, the driven code is 0 (minimum impedance) and the settle flag is low.
- R2: An update opportunity is a rising clock edge where `outDisable` is high, or where `cycWrite` or `cycDesel` is high and `cycRead` is low. On every other edge the driven code keeps its value.
- R3: An edge where `cycRead` is high and `outDisable` is low never changes the driven code, even if `cycWrite` or `cycDesel` is also high.
- R4: At an opportunity the code rises by exactly 1 if it is below the effective target, falls by exactly 1 if it is above it, and is unchanged if equal. The new value is visible after that edge.
- R5: The code never wraps. At all-ones it never goes to 0 on the next edge, and at 0 it never goes to all-ones.
- R6: While `refOpen` is high the effective target is the all-ones (maximum impedance) code, whatever `targetCode` holds.
- R7: A match count rises by 1 (saturating at all-ones) at each opportunity where code equals effective target, and is cleared at an opportunity where they differ. `settled` is registered and is high when the count is nonzero and at least `settleReq`; a `settleReq` of 0 acts as 1.
- R8: From reset, the code reaches any target after exactly as many opportunities as the target's distance from 0, at most 2^CODE_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| targetCode | input | CODE_W | Code requested by the impedance comparator |
| refOpen | input | 1 | Reference is open or tied high; force maximum-impedance target |
| cycWrite | input | 1 | Current cycle is a write |
| cycDesel | input | 1 | Current cycle is deselected |
| cycRead | input | 1 | Current cycle is a read |
| outDisable | input | 1 | Output enable inactive, sampled with setup and hold at the edge |
| settleReq | input | MATCH_W | Consecutive matching opportunities needed to raise `settled` |
| drvCode | output | CODE_W | Impedance code applied to the output drivers |
| settled | output | 1 | Code has agreed with target for `settleReq` opportunities |

## Verification
The bench goes after the cases where a read and a write or deselect flag overlap. A design that let the write flag win would retune a driver in the middle of read data. It also checks that a disabled output during a read does open a window; a design that ignored it would converge more slowly than the bench's count predicts.

Full upward convergence with the reference open is counted edge by edge. A multi-step or wrapping code would miss the exact 2^CODE_W-1 count or drop to 0 at the top. The settle flag is checked for its count, its clear on a target change, and its treatment of a zero requirement; an off-by-one counter raises it one opportunity early or late.

// File: rtl/imp_seq_pkg.sv
package imp_seq_pkg;
  // Strobes from the control half to the code register.
  typedef struct packed {
    logic stepUp;
    logic stepDn;
  } impStrobe_t;
endpackage

// File: rtl/imp_seq_ctrl.sv
module imp_seq_ctrl
  import imp_seq_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int MATCH_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CODE_W-1:0]  targetCode,
  input  logic               refOpen,
  input  logic               cycWrite,
  input  logic               cycDesel,
  input  logic               cycRead,
  input  logic               outDisable,
  input  logic [MATCH_W-1:0] settleReq,
  input  logic [CODE_W-1:0]  curCode,
  output impStrobe_t         strobe,
  output logic               settled
);
  localparam logic [CODE_W-1:0]  CODE_MAX = '1;
  localparam logic [MATCH_W-1:0] CNT_MAX  = '1;
  localparam logic [MATCH_W-1:0] CNT_ONE  = MATCH_W'(1);

  logic               drivingRead;
  logic               window;
  logic [CODE_W-1:0]  effTarget;
  logic [MATCH_W-1:0] matchCnt;
  logic [MATCH_W-1:0] matchNxt;
  logic [MATCH_W-1:0] reqEff;

  // Bus is high-Z when outputs are disabled, or on a write/deselect
  // cycle that is not also driving read data.
  always_comb begin
    effTarget   = refOpen ? CODE_MAX : targetCode;
    drivingRead = cycRead & ~outDisable;
    window      = outDisable | ((cycWrite | cycDesel) & ~drivingRead);
    strobe.stepUp = window && (curCode < effTarget);
    strobe.stepDn = window && (curCode > effTarget);
    reqEff = (settleReq == '0) ? CNT_ONE : settleReq;
  end

  always_comb begin
    matchNxt = matchCnt;
    if (window) begin
      if (curCode == effTarget)
        matchNxt = (matchCnt == CNT_MAX) ? matchCnt : matchCnt + CNT_ONE;
      else
        matchNxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchCnt <= '0;
      settled  <= 1'b0;
    end else begin
      matchCnt <= matchNxt;
      settled  <= (matchNxt != '0) && (matchNxt >= reqEff);
    end
  end

  // A step means the code disagreed, so the flag must be low afterwards.
  p_step_drops_settle_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp || strobe.stepDn) |=> !settled);

  // The flag never stands without at least one recorded match.
  p_settle_has_match_r7 : assert property (@(posedge clk) disable iff (!rstN)
    settled |-> (matchCnt != '0));
endmodule

// File: rtl/imp_seq_dpath.sv
module imp_seq_dpath
  import imp_seq_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  impStrobe_t        strobe,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] STEP     = CODE_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      code <= CODE_MIN;
    else if (strobe.stepUp && (code != CODE_MAX))
      code <= code + STEP;
    else if (strobe.stepDn && (code != CODE_MIN))
      code <= code - STEP;
  end

  p_one_step_r4 : assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((code == $past(code)) ||
              (code == CODE_W'($past(code) + STEP)) ||
              (code == CODE_W'($past(code) - STEP))));

  p_no_wrap_top_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (code == CODE_MAX) |=> (code != CODE_MIN));

  p_no_wrap_bottom_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (code == CODE_MIN) |=> (code != CODE_MAX));
endmodule

// File: rtl/imp_code_sequencer.sv
module imp_code_sequencer
  import imp_seq_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int MATCH_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CODE_W-1:0]  targetCode,
  input  logic               refOpen,
  input  logic               cycWrite,
  input  logic               cycDesel,
  input  logic               cycRead,
  input  logic               outDisable,
  input  logic [MATCH_W-1:0] settleReq,
  output logic [CODE_W-1:0]  drvCode,
  output logic               settled
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  impStrobe_t strobe;

  imp_seq_ctrl #(.CODE_W(CODE_W), .MATCH_W(MATCH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .targetCode(targetCode), .refOpen(refOpen),
    .cycWrite(cycWrite), .cycDesel(cycDesel), .cycRead(cycRead),
    .outDisable(outDisable), .settleReq(settleReq), .curCode(drvCode),
    .strobe(strobe), .settled(settled)
  );

  imp_seq_dpath #(.CODE_W(CODE_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .code(drvCode)
  );

  p_hold_outside_window_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (!outDisable && !((cycWrite || cycDesel) && !cycRead)) |=> $stable(drvCode));

  p_read_hold_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (cycRead && !outDisable) |=> $stable(drvCode));

  p_open_ref_climbs_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (refOpen && cycWrite && !cycRead && (drvCode != CODE_MAX))
      |=> (drvCode == CODE_W'($past(drvCode) + 1'b1)));
endmodule

// File: tb/tb_imp_code_sequencer.sv
module tb_imp_code_sequencer;
  localparam int CODE_W  = 7;
  localparam int MATCH_W = 4;
  localparam int CMAX    = (1 << CODE_W) - 1;
  localparam int NMAX    = (1 << MATCH_W) - 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [CODE_W-1:0]  targetCode = '0;
  logic               refOpen = 1'b0;
  logic               cycWrite = 1'b0, cycDesel = 1'b0, cycRead = 1'b0, outDisable = 1'b0;
  logic [MATCH_W-1:0] settleReq = MATCH_W'(3);
  logic [CODE_W-1:0]  drvCode;
  logic               settled;

  int nChecks = 0;
  int nFails  = 0;
  int mCode = 0, mCnt = 0;
  bit mSet = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  imp_code_sequencer #(.CODE_W(CODE_W), .MATCH_W(MATCH_W)) dut (
    .clk(clk), .rstN(rstN), .targetCode(targetCode), .refOpen(refOpen),
    .cycWrite(cycWrite), .cycDesel(cycDesel), .cycRead(cycRead),
    .outDisable(outDisable), .settleReq(settleReq),
    .drvCode(drvCode), .settled(settled)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle's flags at a falling edge, predict, compare at the next falling edge.
  task automatic cyc(input bit w, input bit d, input bit z, input bit r, input string tag);
    int eff;
    int req;
    bit win;
    cycWrite = w; cycDesel = d; outDisable = z; cycRead = r;
    eff = refOpen ? CMAX : int'(targetCode);
    win = z || ((w || d) && !r);
    if (win) begin
      if (mCode == eff) mCnt = (mCnt == NMAX) ? mCnt : mCnt + 1;
      else begin
        mCnt = 0;
        mCode = (mCode < eff) ? mCode + 1 : mCode - 1;
      end
    end
    req = (settleReq == 0) ? 1 : int'(settleReq);
    mSet = (mCnt != 0) && (mCnt >= req);
    @(negedge clk);
    chk({tag, " code"}, int'(drvCode), mCode);
    chk({tag, " settled"}, int'(settled), int'(mSet));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cycWrite = 0; cycDesel = 0; outDisable = 0; cycRead = 0;
    mCode = 0; mCnt = 0; mSet = 0;
    @(negedge clk);
    chk("R1 in reset code", int'(drvCode), 0);
    chk("R1 in reset settled", int'(settled), 0);
    rstN = 1'b1;
    cyc(0, 0, 0, 0, "R1 after release");
  endtask

  task automatic tWriteSettle();
    refOpen = 0; targetCode = 5; settleReq = 3;
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R4 write step up");
    chk("R4 reached target", int'(drvCode), 5);
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, "R7 below settle count");
    chk("R7 not yet settled", int'(settled), 0);
    cyc(1, 0, 0, 0, "R7 third match");
    chk("R7 settled after three", int'(settled), 1);
  endtask

  task automatic tReadBlock();
    targetCode = 9;
    cyc(0, 0, 0, 1, "R3 plain read");
    cyc(1, 0, 0, 1, "R3 read with write flag");
    cyc(0, 1, 0, 1, "R3 read with deselect flag");
    cyc(0, 0, 0, 0, "R2 idle");
    chk("R3 code held at 5", int'(drvCode), 5);
    chk("R7 flag holds without window", int'(settled), 1);
  endtask

  task automatic tOtherWindows();
    cyc(0, 0, 1, 1, "R2 read with outputs disabled");
    chk("R2 disabled read steps", int'(drvCode), 6);
    chk("R7 miss clears flag", int'(settled), 0);
    cyc(0, 1, 0, 0, "R2 deselect");
    cyc(0, 0, 1, 0, "R2 output disable alone");
    cyc(0, 1, 0, 0, "R2 deselect to target");
    chk("R2 reached 9", int'(drvCode), 9);
  endtask

  task automatic tStepDown();
    targetCode = 2; settleReq = 0;
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, "R4 write step down");
    chk("R4 down to 2", int'(drvCode), 2);
    cyc(0, 1, 0, 0, "R7 zero requirement acts as one");
    chk("R7 settled with req 0", int'(settled), 1);
  endtask

  task automatic tRefOpen();
    int n;
    doReset();
    refOpen = 1; targetCode = 3; settleReq = 2;
    n = 0;
    for (int i = 0; i < CMAX - 1; i++) begin
      cyc(1, 0, 0, 0, "R6 open reference climb");
      n++;
    end
    chk("R8 one short of top", int'(drvCode), CMAX - 1);
    cyc(1, 0, 0, 0, "R8 final step");
    n++;
    chk("R8 top reached in count", int'(drvCode), CMAX);
    chk("R8 opportunities used", n, CMAX);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, "R5 held at top");
    chk("R5 no wrap at top", int'(drvCode), CMAX);
    chk("R7 settled at top", int'(settled), 1);
  endtask

  task automatic tBottom();
    doReset();
    refOpen = 0; targetCode = 0; settleReq = 15;
    for (int i = 0; i < 17; i++) cyc(1, 0, 0, 0, "R5 held at bottom");
    chk("R5 no wrap at bottom", int'(drvCode), 0);
    chk("R7 saturated count settled", int'(settled), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    tWriteSettle();
    tReadBlock();
    tOtherWindows();
    tStepDown();
    tRefOpen();
    tBottom();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule